// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is a general-purpose I/O port of `WIDTH` pins (eight by default) behind a simple memory-mapped register bus. Its main feature is a data register spread over a window of `2^WIDTH` words. The word address of a data access also acts as a per-bit mask. A single store can therefore set or clear any subset of pins without a read-modify-write sequence. Software forms the store address by shifting the pin mask left by two. The written value then supplies the new levels for the pins that the mask selects.

A direction register follows directly above the data window and makes each pin an output or an input. Pin levels are brought into the clock domain through a synchronizer before a read returns them. A read of the data window returns the pin levels through the same address mask. Bus access only works once a clock-enable request has been held for a set number of cycles. Until then the port ignores writes and returns zero on reads.

Top module: `masked_gpio_port`

## Requirements
- R1: After reset the data and direction registers are zero, so `pin_oe` and `pin_out` are all zero and every pin is an input.
- R2: Writes are ignored and reads return 0 until `clk_en_req` has been sampled high on `EN_DELAY` (3) consecutive rising edges. When `clk_en_req` is sampled low, the port returns to that ignoring state.
- R3: A write to a data-window word, where `bus_addr[WIDTH+1:2]` is the mask m and the address bits above are zero, loads `bus_wdata[i]` into data bit i for each bit with m[i]=1. Every bit with m[i]=0 keeps its value.
- R4: A write at byte offset 0x000 (mask 0) changes no data bit. A write at offset 0x3FC (all mask bits set) replaces all eight data bits.
- R5: A read of a data-window word returns the synchronized pin level in each bit where the mask is 1. Every other bit of `bus_rdata`, including all bits above `WIDTH`, reads 0.
- R6: The direction register sits at byte offset 0x400. A write there loads `bus_wdata[WIDTH-1:0]` (1 = output), and a read there returns it in the low bits.
- R7: `pin_oe` equals the direction register. `pin_out[i]` carries data bit i when direction bit i is 1 and is 0 otherwise.
- R8: A change on `pin_in` becomes visible to reads after exactly `SYNC_STAGES` (2) rising edges, and not after fewer.
- R9: Writes to addresses outside the data window and the direction word change nothing, and reads from those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_req | input | 1 | Clock-enable request; must be held to keep the port usable |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset inside the port window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of the access |
| pin_in | input | WIDTH | Pad levels |
| pin_out | output | WIDTH | Output level per pin |
| pin_oe | output | WIDTH | Output enable per pin |

## Verification
The bench builds the port with its defaults: eight pins, a 4 KB window, a 32-bit bus, a three-cycle enable delay and two synchronizer stages. At eight pins the mask space has only 256 values. The bench therefore sweeps every mask for both writes and reads and computes each expected register value arithmetically from the previous one. The short enable delay and shallow synchronizer allow an edge-exact check of the cycle in which access starts and the cycle in which an input change first appears.

// File: rtl/mgp_pkg.sv
package mgp_pkg;

   // Decoded target of one bus access
   typedef enum logic [1:0] {
      MGP_SEL_NONE = 2'd0,
      MGP_SEL_DATA = 2'd1,
      MGP_SEL_DIR  = 2'd2
   } mgp_sel_e;

   // Byte offset of the direction word for a port of the given width
   function automatic int unsigned mgp_dir_offset(input int unsigned width);
      return 32'd1 << (width + 2);
   endfunction

endpackage

// File: rtl/mgp_enable_gate.sv
module mgp_enable_gate #(
   parameter int unsigned EN_DELAY = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic ready
);
   localparam int unsigned CW = $clog2(EN_DELAY + 1);
   localparam logic [CW-1:0] CNT_MAX = CW'(EN_DELAY);

   generate
      if (EN_DELAY < 1) begin : g_bad_delay
         $error("mgp_enable_gate: EN_DELAY must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (!req)             cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
   end

   assign ready = (cnt_q == CNT_MAX);

   AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> !ready); // R2
   AST_READY_NEEDS_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(req)); // R2
endmodule

// File: rtl/mgp_in_sync.sv
module mgp_in_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mgp_in_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stg_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg_q[0] <= '0;
               else        stg_q[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg_q[s] <= '0;
               else        stg_q[s] <= stg_q[s-1];
            end
         end
      end
   endgenerate

   assign q = stg_q[STAGES-1];

   AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(stg_q[0]) |=> (stg_q[1] == $past(stg_q[0]))); // R8
endmodule

// File: rtl/mgp_regs.sv
module mgp_regs #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             data_we,
   input  logic             dir_we,
   input  logic [WIDTH-1:0] mask,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] data_q,
   output logic [WIDTH-1:0] dir_q
);
   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  data_q[i] <= 1'b0;
            else if (data_we && mask[i]) data_q[i] <= wdata[i];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dir_q <= '0;
      else if (dir_we) dir_q <= wdata;
   end

   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !data_we |=> $stable(data_q)); // R3
   AST_UNMASKED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      data_we |=> (((data_q ^ $past(data_q)) & ~$past(mask)) == '0)); // R3
   AST_MASKED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      data_we |=> (((data_q ^ $past(wdata)) & $past(mask)) == '0)); // R3
   AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      dir_we |=> (dir_q == $past(wdata))); // R6
   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      !(data_we && dir_we)); // R9
endmodule

// File: rtl/masked_gpio_port.sv
module masked_gpio_port
   import mgp_pkg::*;
#(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned EN_DELAY    = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en_req,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [WIDTH-1:0]  pin_in,
   output logic [WIDTH-1:0]  pin_out,
   output logic [WIDTH-1:0]  pin_oe
);
   localparam int unsigned MASK_LSB = 2;
   localparam int unsigned WIN_LSB  = WIDTH + MASK_LSB;
   localparam int unsigned WORD_W   = ADDR_W - MASK_LSB;
   localparam logic [WORD_W-1:0] DIR_WORD = WORD_W'(mgp_dir_offset(WIDTH) >> MASK_LSB);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("masked_gpio_port: WIDTH must be at least 1");
      end
      if (ADDR_W <= WIN_LSB) begin : g_bad_addr
         $error("masked_gpio_port: ADDR_W must exceed WIDTH+2");
      end
      if (DATA_W <= WIDTH) begin : g_bad_data
         $error("masked_gpio_port: DATA_W must exceed WIDTH");
      end
   endgenerate

   logic             ready;
   logic [WIDTH-1:0] in_sync;
   logic [WIDTH-1:0] data_q;
   logic [WIDTH-1:0] dir_q;
   logic [WIDTH-1:0] acc_mask;
   mgp_sel_e         target;
   logic             data_we;
   logic             dir_we;
   logic             unused_bits;

   mgp_enable_gate #(.EN_DELAY(EN_DELAY)) en_gate_i (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (clk_en_req),
      .ready (ready)
   );

   mgp_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) in_sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (in_sync)
   );

   // Address decode: data window when every bit above the mask is zero
   always_comb begin
      target = MGP_SEL_NONE;
      if (bus_addr[ADDR_W-1:WIN_LSB] == '0)             target = MGP_SEL_DATA;
      else if (bus_addr[ADDR_W-1:MASK_LSB] == DIR_WORD) target = MGP_SEL_DIR;
   end

   assign acc_mask = bus_addr[WIN_LSB-1:MASK_LSB];
   assign data_we  = ready && bus_sel && bus_wr && (target == MGP_SEL_DATA);
   assign dir_we   = ready && bus_sel && bus_wr && (target == MGP_SEL_DIR);

   mgp_regs #(.WIDTH(WIDTH)) regs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .data_we (data_we),
      .dir_we  (dir_we),
      .mask    (acc_mask),
      .wdata   (bus_wdata[WIDTH-1:0]),
      .data_q  (data_q),
      .dir_q   (dir_q)
   );

   always_comb begin
      bus_rdata = '0;
      if (ready && bus_sel && !bus_wr) begin
         unique case (target)
            MGP_SEL_DATA: bus_rdata = {{(DATA_W-WIDTH){1'b0}}, in_sync & acc_mask};
            MGP_SEL_DIR:  bus_rdata = {{(DATA_W-WIDTH){1'b0}}, dir_q};
            default:      bus_rdata = '0;
         endcase
      end
   end

   assign pin_oe  = dir_q;
   assign pin_out = data_q & dir_q;

   assign unused_bits = ^{bus_addr[MASK_LSB-1:0], bus_wdata[DATA_W-1:WIDTH]};

   AST_IDLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> (bus_rdata == '0)); // R2
   AST_DRIVE_ONLY_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_out & ~pin_oe) == '0)); // R7
   AST_READ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && target == MGP_SEL_DATA) |-> ((bus_rdata[WIDTH-1:0] & ~acc_mask) == '0)); // R5
   AST_FAR_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && target == MGP_SEL_NONE) |=> ($stable(pin_out) && $stable(pin_oe))); // R9
endmodule

// File: tb/masked_gpio_port_tb_top.sv
module masked_gpio_port_tb_top;
   localparam int W  = 8;
   localparam int AW = 12;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clk_en_req = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic [W-1:0]  pin_in;
   logic [W-1:0]  pin_out;
   logic [W-1:0]  pin_oe;
   logic [W-1:0]  ext = '0;

   int n_chk  = 0;
   int n_fail = 0;
   logic done = 1'b0;

   always #5 clk = ~clk;

   // Pad model: driven pins read back their own level, others follow ext
   assign pin_in = (pin_out & pin_oe) | (ext & ~pin_oe);

   masked_gpio_port dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .clk_en_req (clk_en_req),
      .bus_sel    (bus_sel),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .pin_in     (pin_in),
      .pin_out    (pin_out),
      .pin_oe     (pin_oe)
   );

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Both tasks start at a falling edge and return at the next one
   task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   initial begin
      logic [DW-1:0] rd;
      logic [W-1:0]  exp_d;
      logic [W-1:0]  wd;
      logic [W-1:0]  m;

      repeat (3) @(negedge clk);
      check("R1 oe after reset", {24'h0, pin_oe}, 32'h0);
      check("R1 out after reset", {24'h0, pin_out}, 32'h0);
      rst_n = 1'b1;
      ext = 8'hFF;
      idle(3);

      // R2: no request yet, reads give 0 and writes are dropped
      bus_read(12'h3FC, rd);
      check("R2 read before enable", rd, 32'h0);
      bus_write(12'h400, 32'hFF);
      check("R2 write before enable", {24'h0, pin_oe}, 32'h0);

      // R2: write sampled at the third edge of the request is still ignored
      clk_en_req = 1'b1;
      idle(2);
      bus_write(12'h400, 32'hFF);
      check("R2 write at edge EN_DELAY", {24'h0, pin_oe}, 32'h0);
      bus_write(12'h400, 32'hFFFF_FF0F);
      check("R2/R6 first accepted write", {24'h0, pin_oe}, 32'h0F);
      bus_read(12'h400, rd);
      check("R6 direction readback", rd, 32'h0F);
      bus_write(12'h400, 32'hFF);
      check("R7 oe equals direction", {24'h0, pin_oe}, 32'hFF);

      // R3/R4: sweep every mask, expected value folded arithmetically
      exp_d = '0;
      for (int i = 0; i < 256; i++) begin
         m  = W'(i);
         wd = W'((i * 73 + 29) % 256);
         bus_write({2'b00, m, 2'b00}, {24'hA5C3E1, wd});
         exp_d = (exp_d & ~m) | (wd & m);
         if (i == 0 || i == 255) check("R4 mask extremes", {24'h0, pin_out}, {24'h0, exp_d});
         else                    check("R3 masked write", {24'h0, pin_out}, {24'h0, exp_d});
      end
      bus_write(12'h000, 32'hFF);
      check("R4 zero mask no change", {24'h0, pin_out}, {24'h0, exp_d});
      bus_write(12'h3FC, 32'h5A);
      exp_d = 8'h5A;
      check("R4 full mask", {24'h0, pin_out}, 32'h5A);

      // R5: masked read sweep with all pins driven
      idle(3);
      for (int i = 0; i < 256; i++) begin
         m = W'(i);
         bus_read({2'b00, m, 2'b00}, rd);
         check("R5 masked read", rd, {24'h0, exp_d & m});
      end

      // R7: mixed direction
      bus_write(12'h400, 32'h0F);
      ext = 8'hC3;
      check("R7 out gated by direction", {24'h0, pin_out}, {24'h0, exp_d & 8'h0F});
      idle(3);
      bus_read(12'h3FC, rd);
      check("R5/R7 mixed pin read", rd, {24'h0, (exp_d & 8'h0F) | (8'hC3 & 8'hF0)});

      // R8: input change visible after exactly two edges
      bus_write(12'h400, 32'h00);
      ext = 8'h3C;
      idle(3);
      ext = 8'hA5;
      @(negedge clk);
      bus_read(12'h3FC, rd);
      check("R8 not visible after one edge", rd, 32'h3C);
      bus_read(12'h3FC, rd);
      check("R8 visible after two edges", rd, 32'hA5);

      // R9: accesses outside both decoded words
      bus_write(12'h400, 32'hFF);
      bus_write(12'h404, 32'h00);
      check("R9 write 0x404 dir kept", {24'h0, pin_oe}, 32'hFF);
      bus_write(12'h800, 32'h00);
      check("R9 write 0x800 data kept", {24'h0, pin_out}, {24'h0, exp_d});
      bus_read(12'h404, rd);
      check("R9 read 0x404", rd, 32'h0);
      bus_read(12'hFFC, rd);
      check("R9 read 0xFFC", rd, 32'h0);

      // R2: dropping the request blocks access again
      clk_en_req = 1'b0;
      @(negedge clk);
      bus_write(12'h3FC, 32'h00);
      check("R2 write after drop", {24'h0, pin_out}, {24'h0, exp_d});
      bus_read(12'h400, rd);
      check("R2 read after drop", rd, 32'h0);

      // R1: reset again clears everything
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset clears oe", {24'h0, pin_oe}, 32'h0);
      check("R1 reset clears out", {24'h0, pin_out}, 32'h0);
      done = 1'b1;
   end

   initial begin
      for (int t = 0; t < 100000; t++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule